// File: doc/BRIEF.md
# Watchdog Counter with Timed Reset Output

This block is an up-counting watchdog that advances on a peripheral-clock tick. Software sets three control bits: mode select, timer enable and reset enable. It reloads the counter before it runs past its top value, and it reads and clears an overflow flag. The block is in watchdog mode only when the mode-select bit and the timer-enable bit are both set.

In watchdog mode, a counter step past the top value sets the overflow flag. If reset enable is also set, the block raises an internal reset output for a fixed number of clocks. While that pulse is high, the counter and the control bits are held at zero. The flag survives the pulse, so software can find out why the reset happened.

An external reset pin clears every register. It ends any pulse in progress. If it arrives in the same cycle as an overflow, it wins and the flag stays clear.

Top module: `wdog_rst_gen`

## Requirements
- R1: A counter step past the top value sets the flag only when `ctl_wdata[0]` (mode select) and `ctl_wdata[1]` (timer enable), as last written, are both 1. In interval mode (only bit 1 set) the counter wraps to 0 without setting the flag.
- R2: When the timer is enabled, the counter starts at 0 and rises by one on each clock where `tick` is high, and only then. The step past 2^CNT_W-1 gives 0.
- R3: While the timer-enable bit is 0, the counter reads 0 and no tick can move it or cause an overflow.
- R4: A watchdog-mode overflow sets `flag_o` to 1 on the next clock, whatever the value of the reset-enable bit (`ctl_wdata[2]`).
- R5: When reset enable is 1, an overflow raises `int_rst_o` from the next clock on, for exactly PULSE_LEN consecutive clocks.
- R6: When reset enable is 0, an overflow leaves `int_rst_o` low.
- R7: While `int_rst_o` is high, `cnt_o` and `ctl_o` read 0 and writes to them are ignored. `flag_o` keeps its value.
- R8: A counter write loads `cnt_wdata` on the next clock and takes priority over a tick in the same cycle. A write in the top-value cycle therefore prevents the overflow.
- R9: `ext_rst` clears the counter, the control bits and the flag, and drops `int_rst_o` on the next clock. An overflow in the same cycle as `ext_rst` leaves the flag at 0.
- R10: `flag_clr` clears the flag only after `flag_rd` has been pulsed while the flag read 1. A clear without that read is ignored, and an overflow in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| ext_rst | input | 1 | External reset pin, synchronous, active high |
| tick | input | 1 | Single-cycle count enable |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Bit 2 reset enable, bit 1 timer enable, bit 0 mode select |
| cnt_we | input | 1 | Counter reload strobe |
| cnt_wdata | input | CNT_W | Counter reload value |
| flag_rd | input | 1 | Software read of the overflow flag |
| flag_clr | input | 1 | Software write of 0 to the overflow flag |
| cnt_o | output | CNT_W | Counter value |
| ctl_o | output | 3 | Control bits, same layout as ctl_wdata |
| flag_o | output | 1 | Overflow flag |
| int_rst_o | output | 1 | Internal reset pulse |

## Verification
The bench builds the block with its default values: an 8-bit counter and a 519-clock pulse. A full run from 0 to rollover takes 256 ticks. The full pulse takes 519 clocks, so every pulse-length and wrap check is done at the real size, not a scaled-down one. The bench presets the counter just under the top value to reach each overflow within a few clocks. This keeps the same-cycle cases within reach: a tick together with a reload, and an overflow together with an external reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Control bits; packed order gives rst_en bit 2, tm_en bit 1, wd_mode bit 0.
    typedef struct packed {
        logic rst_en;
        logic tm_en;
        logic wd_mode;
    } wdog_ctl_t;

    localparam int unsigned CTL_W = $bits(wdog_ctl_t);

    // Flag life cycle: clear, set, set and seen by software.
    typedef enum logic [1:0] {
        FLAG_IDLE  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_ARMED = 2'd2
    } flag_state_e;

    function automatic logic wd_active(input wdog_ctl_t c);
        return c.wd_mode & c.tm_en;
    endfunction

    function automatic logic flag_visible(input flag_state_e s);
        return s != FLAG_IDLE;
    endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             hold,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t TOP = {CNT_W{1'b1}};

    assign wrap = en && !hold && !we && tick && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst || hold || !en) begin
            cnt_q <= '0;
        end else if (we) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: a disabled timer leaves the counter at zero
    p_off_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt_q == '0);

    // R2: one step per tick, wrapping at the top
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !we && !hold) |=> cnt_q == cnt_t'($past(cnt_q) + 1'b1));

    // R8: reload wins over a tick
    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (en && we && !hold) |=> cnt_q == $past(wdata));

endmodule

// File: rtl/wdog_ctl_regs.sv
module wdog_ctl_regs
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        busy,
    input  logic        ovf,
    input  logic        ctl_we,
    input  wdog_ctl_t   ctl_wdata,
    input  logic        flag_rd,
    input  logic        flag_clr,
    output wdog_ctl_t   ctl_q,
    output flag_state_e fstate_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            fstate_q <= FLAG_IDLE;
        end else if (busy) begin
            ctl_q <= '0;
            if (fstate_q == FLAG_ARMED) begin
                fstate_q <= FLAG_SET;
            end
        end else begin
            if (ovf && ctl_q.rst_en) begin
                ctl_q <= '0;
            end else if (ctl_we) begin
                ctl_q <= ctl_wdata;
            end

            if (ovf) begin
                fstate_q <= FLAG_SET;
            end else begin
                unique case (fstate_q)
                    FLAG_SET:   if (flag_rd)  fstate_q <= FLAG_ARMED;
                    FLAG_ARMED: if (flag_clr) fstate_q <= FLAG_IDLE;
                    default:    fstate_q <= fstate_q;
                endcase
            end
        end
    end

    // R4: an overflow always raises the flag
    p_ovf_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (ovf && !busy) |=> fstate_q == FLAG_SET);

    // R7: control bits sit at zero during the pulse
    p_ctl_held_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> ctl_q == '0);

    // R10: a flag not yet read cannot be cleared
    p_clr_needs_read_r10: assert property (@(posedge clk) disable iff (rst)
        (fstate_q == FLAG_SET) |=> fstate_q != FLAG_IDLE);

endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
    parameter int unsigned PULSE_LEN = 519
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int unsigned PW = $clog2(PULSE_LEN + 1);
    typedef logic [PW-1:0] len_t;
    localparam len_t LOAD = len_t'(PULSE_LEN);

    len_t remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end else if (start) begin
            remain_q <= LOAD;
        end
    end

    assign busy = (remain_q != '0);

    // Checker counter: length of the current high run of busy
    logic [PW:0] hi_q;
    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            hi_q <= busy ? (PW+1)'(1) : '0;
        end else begin
            hi_q <= hi_q + 1'b1;
        end
    end

    // R5: the pulse starts on the clock after the request
    p_start_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R5: a pulse that ends without an external reset lasted PULSE_LEN clocks
    p_len_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy) && !$past(rst)) |-> hi_q == (PW+1)'(PULSE_LEN));

endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned PULSE_LEN = 519
) (
    input  logic             clk,
    input  logic             ext_rst,
    input  logic             tick,
    input  logic             ctl_we,
    input  logic [2:0]       ctl_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             flag_rd,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic [2:0]       ctl_o,
    output logic             flag_o,
    output logic             int_rst_o
);
    wdog_ctl_t   ctl_q;
    flag_state_e fstate_q;
    logic        wrap, ovf, start, busy;

    assign ovf   = wrap && wd_active(ctl_q);
    assign start = ovf && ctl_q.rst_en;

    wdog_counter #(.CNT_W(CNT_W)) i_counter (
        .clk   (clk),
        .rst   (ext_rst),
        .tick  (tick),
        .en    (ctl_q.tm_en),
        .hold  (busy),
        .we    (cnt_we),
        .wdata (cnt_wdata),
        .cnt_q (cnt_o),
        .wrap  (wrap)
    );

    wdog_ctl_regs i_regs (
        .clk       (clk),
        .rst       (ext_rst),
        .busy      (busy),
        .ovf       (ovf),
        .ctl_we    (ctl_we),
        .ctl_wdata (wdog_ctl_t'(ctl_wdata)),
        .flag_rd   (flag_rd),
        .flag_clr  (flag_clr),
        .ctl_q     (ctl_q),
        .fstate_q  (fstate_q)
    );

    wdog_pulse_gen #(.PULSE_LEN(PULSE_LEN)) i_pulse (
        .clk   (clk),
        .rst   (ext_rst),
        .start (start),
        .busy  (busy)
    );

    assign ctl_o     = ctl_q;
    assign flag_o    = flag_visible(fstate_q);
    assign int_rst_o = busy;

    // R1: the flag cannot rise outside watchdog mode
    p_only_wd_mode_r1: assert property (@(posedge clk) disable iff (ext_rst)
        (!wd_active(ctl_q) && !busy) |=> !$rose(flag_o));

    // R6: no pulse when reset enable is off
    p_no_pulse_r6: assert property (@(posedge clk) disable iff (ext_rst)
        (ovf && !ctl_q.rst_en && !int_rst_o) |=> !int_rst_o);

    // R9: the external reset clears everything, even with an overflow pending
    p_extrst_r9: assert property (@(posedge clk)
        ext_rst |=> (!int_rst_o && !flag_o && cnt_o == '0 && ctl_o == '0));

endmodule

// File: tb/test_wdog_rst_gen.sv
module test_wdog_rst_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int PULSE_LEN  = 519;
    localparam int TOPV       = (1 << CNT_W) - 1;
    localparam int WATCHDOG   = 100000;

    typedef logic [CNT_W-1:0] cnt_t;

    logic clk = 1'b0;
    logic ext_rst = 1'b1, tick = 1'b0, ctl_we = 1'b0, cnt_we = 1'b0;
    logic flag_rd = 1'b0, flag_clr = 1'b0;
    logic [2:0] ctl_wdata = '0;
    cnt_t cnt_wdata = '0;
    cnt_t cnt_o;
    logic [2:0] ctl_o;
    logic flag_o, int_rst_o;

    int vectors = 0, fails = 0, cyc = 0;
    bit go = 0;

    // behavioural model state
    int m_cnt = 0, m_ctl = 0, m_flag = 0, m_armed = 0, m_pulse = 0;

    wdog_rst_gen #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) i_wdog_rst_gen (
        .clk(clk), .ext_rst(ext_rst), .tick(tick), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .flag_rd(flag_rd), .flag_clr(flag_clr), .cnt_o(cnt_o), .ctl_o(ctl_o),
        .flag_o(flag_o), .int_rst_o(int_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        int n_cnt, n_ctl, n_flag, n_armed, n_pulse;
        bit en, ovf;
        go = 1;
        n_cnt = m_cnt; n_ctl = m_ctl; n_flag = m_flag; n_armed = m_armed; n_pulse = m_pulse;
        if (ext_rst) begin
            n_cnt = 0; n_ctl = 0; n_flag = 0; n_armed = 0; n_pulse = 0;
        end else if (m_pulse > 0) begin
            n_pulse = m_pulse - 1; n_cnt = 0; n_ctl = 0; n_armed = 0;
        end else begin
            en  = m_ctl[1];
            ovf = m_ctl[0] && en && tick && !cnt_we && m_cnt == TOPV;
            if (!en) n_cnt = 0;
            else if (cnt_we) n_cnt = int'(cnt_wdata);
            else if (tick) n_cnt = (m_cnt + 1) % (TOPV + 1);
            if (ctl_we) n_ctl = int'(ctl_wdata);
            if (ovf) begin n_flag = 1; n_armed = 0; end
            else if (flag_clr && m_armed == 1) begin n_flag = 0; n_armed = 0; end
            else if (flag_rd && m_flag == 1) n_armed = 1;
            if (ovf && m_ctl[2]) begin n_pulse = PULSE_LEN; n_cnt = 0; n_ctl = 0; end
        end
        m_cnt = n_cnt; m_ctl = n_ctl; m_flag = n_flag; m_armed = n_armed; m_pulse = n_pulse;
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (go) begin
            vectors++;
            if (cnt_o !== cnt_t'(m_cnt)) begin
                fails++; $display("FAIL R2 cnt_o: actual %0h expected %0h", cnt_o, m_cnt);
            end
            if (ctl_o !== 3'(m_ctl)) begin
                fails++; $display("FAIL R7 ctl_o: actual %0h expected %0h", ctl_o, m_ctl);
            end
            if (flag_o !== 1'(m_flag)) begin
                fails++; $display("FAIL R4 flag_o: actual %0b expected %0b", flag_o, m_flag);
            end
            if (int_rst_o !== (m_pulse > 0)) begin
                fails++; $display("FAIL R5 int_rst_o: actual %0b expected %0b", int_rst_o, m_pulse > 0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [2:0] v);
        @(negedge clk); ctl_we = 1; ctl_wdata = v;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic wr_cnt(input int v);
        @(negedge clk); cnt_we = 1; cnt_wdata = cnt_t'(v);
        @(negedge clk); cnt_we = 0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
            repeat (gap) @(negedge clk);
        end
    endtask

    initial begin
        int hi;
        bit seen;
        repeat (3) @(negedge clk);
        ext_rst = 0;
        chk(cnt_o == 0 && ctl_o == 0 && !flag_o && !int_rst_o, "R9 reset state", int'(cnt_o), 0);

        // R3: mode set but timer off
        wr_ctl(3'b001);
        ticks(20, 0);
        chk(cnt_o == 0, "R3 disabled counter held", int'(cnt_o), 0);

        // R2: interval mode counting with gaps, then wrap
        wr_ctl(3'b010);
        ticks(10, 2);
        chk(cnt_o == 10, "R2 ten ticks", int'(cnt_o), 10);
        ticks(TOPV + 1 - 10, 0);
        chk(cnt_o == 0, "R2 wrap to zero", int'(cnt_o), 0);
        chk(!flag_o, "R1 interval wrap no flag", int'(flag_o), 0);

        // R8: reload, and reload racing a tick
        wr_cnt(8'hF0);
        chk(cnt_o == 8'hF0, "R8 reload", int'(cnt_o), 8'hF0);
        @(negedge clk); cnt_we = 1; cnt_wdata = 8'h20; tick = 1;
        @(negedge clk); cnt_we = 0; tick = 0;
        chk(cnt_o == 8'h20, "R8 write beats tick", int'(cnt_o), 8'h20);
        wr_cnt(TOPV);
        wr_ctl(3'b011);
        @(negedge clk); cnt_we = 1; cnt_wdata = 8'h05; tick = 1;
        @(negedge clk); cnt_we = 0; tick = 0;
        chk(!flag_o, "R8 write at top prevents overflow", int'(flag_o), 0);

        // R4 / R6: watchdog overflow without reset enable
        wr_cnt(TOPV - 2);
        ticks(3, 0);
        chk(flag_o, "R4 flag set", int'(flag_o), 1);
        chk(cnt_o == 0, "R2 overflow wraps", int'(cnt_o), 0);
        seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (int_rst_o) seen = 1; end
        chk(!seen, "R6 no pulse", int'(seen), 0);

        // R10: clear needs a prior read
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        chk(flag_o, "R10 clear without read ignored", int'(flag_o), 1);
        @(negedge clk); flag_rd = 1;
        @(negedge clk); flag_rd = 0; flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        chk(!flag_o, "R10 clear after read", int'(flag_o), 0);

        // R5 / R7: pulse length and held state
        wr_ctl(3'b111);
        wr_cnt(TOPV);
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        hi = 0;
        while (int_rst_o && hi < 2000) begin
            if (hi == 5) begin ctl_we = 1; ctl_wdata = 3'b011; cnt_we = 1; cnt_wdata = 8'h55; end
            if (hi == 6) begin
                ctl_we = 0; cnt_we = 0;
            end
            if (hi == 8) begin
                chk(cnt_o == 0 && ctl_o == 0, "R7 state held during pulse", int'(cnt_o), 0);
                chk(flag_o, "R7 flag kept during pulse", int'(flag_o), 1);
            end
            hi++;
            @(negedge clk);
        end
        chk(hi == PULSE_LEN, "R5 pulse length", hi, PULSE_LEN);
        chk(ctl_o == 0 && flag_o, "R7 after pulse", int'(ctl_o), 0);

        // R9: external reset aborts a pulse
        wr_ctl(3'b111);
        wr_cnt(TOPV);
        ticks(1, 0);
        repeat (50) @(negedge clk);
        chk(int_rst_o, "R5 pulse running", int'(int_rst_o), 1);
        ext_rst = 1;
        @(negedge clk); ext_rst = 0;
        chk(!int_rst_o && !flag_o, "R9 abort pulse", int'(int_rst_o), 0);

        // R9: external reset in the overflow cycle
        wr_ctl(3'b111);
        wr_cnt(TOPV);
        @(negedge clk); tick = 1; ext_rst = 1;
        @(negedge clk); tick = 0; ext_rst = 0;
        chk(!flag_o && !int_rst_o, "R9 simultaneous reset wins", int'(flag_o), 0);
        repeat (5) @(negedge clk);
        chk(!int_rst_o && cnt_o == 0, "R9 no late pulse", int'(int_rst_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule